// File: doc/BRIEF.md
# Two-Source Coincidence Trigger Former

This block forms physics-style triggers from two asynchronous detector pulses, a primary and a secondary. Both are sampled into a single clock domain, nominally 40 MHz, so all output timing is quantised to the clock phase. The block can jitter by up to one clock period relative to the input edge. Each source opens its own programmable delayed gate, and the two gates are ANDed to form a raw coincidence. That raw coincidence opens a widening gate. The widened window is then ANDed with a delayed copy of the primary, so the primary source alone sets when the coincidence output fires.

Each source also drives a separate delay stage followed by a downscaler, which gives the downscaled singles triggers. All six gate-and-delay stages have a programmable delay, a programmable width and a bypass bit. These settings, and the two prescale factors, are loaded through a simple address/data/write-strobe port.

Top module: `coinc_trigger_former`

## Requirements
- R1: Each source input passes through a two-flop synchroniser and a rising-edge detector. An input held high for any number of cycles (at least one) starts exactly one gate. If E is the first clock edge that samples the input high, the stage start cycle is the cycle that follows edge E+1.
- R2: A gate stage that starts in cycle c, with delay D and width W (both 1..255, 0 treated as 1), drives its output high in cycles c+D+1 through c+D+W.
- R3: The raw coincidence is the AND of the primary gate (stage 0) and the secondary gate (stage 1). The widening stage (stage 2) starts in the first cycle in which the raw coincidence is high.
- R4: coinc_out is high one cycle after a cycle in which both the widened window and the reference stage (stage 3, a delayed copy of the primary) are high. It is never high otherwise.
- R5: Bypass mask bit i (address 12, bits 0..5 map to stages 0..5) makes stage i pass its input straight to its output in the same cycle.
- R6: Stage 4 (primary) and stage 5 (secondary) feed the downscalers. A singles output is a one-cycle pulse, one cycle after the rising edge of its stage output. With prescale 1, delay D and no bypass, single_pri_out is high in the cycle after clock edge E+3+D.
- R7: A downscaler with factor N emits a pulse on input pulses 1, N+1, 2N+1 and so on. N=1 passes every pulse and N=0 passes none.
- R8: A stage ignores any rising edge on its input while it is delaying or gating.
- R9: A write with cfg_we high loads cfg_wdata at the next clock edge. Addresses 0..5 hold the stage delays, 6..11 the stage widths, 12 the bypass mask, 13 the primary prescale and 14 the secondary prescale. The same edge returns every stage to idle and clears both downscaler counts.
- R10: After reset all outputs are low, every delay and width is 1, the bypass mask is 0 and both prescale factors are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| src_pri | input | 1 | Asynchronous primary trigger source |
| src_sec | input | 1 | Asynchronous secondary trigger source |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register address |
| cfg_wdata | input | DATA_W | Configuration write data |
| coinc_out | output | 1 | Primary-timed coincidence trigger |
| single_pri_out | output | 1 | Downscaled primary singles pulse |
| single_sec_out | output | 1 | Downscaled secondary singles pulse |

## Verification
A wrong delay counter shifts the first high cycle of coinc_out or a singles pulse by whole cycles. A wrong width counter changes how many cycles coinc_out stays high. Both faults show within one trigger window, about thirty cycles after the source edge. A stage stuck busy or a missed retrigger shows up as a missing or extra singles pulse on the next source pulse. A wrong downscaler count shows up after at most N+1 source pulses as a wrong pulse pattern. A missing clear on a configuration write shows up as a singles pulse that should have been dropped.

// File: rtl/ctf_pkg.sv
package ctf_pkg;
  localparam int NSTAGE = 6;
  localparam int STG_GATE0 = 0;
  localparam int STG_WIDEN = 2;
  localparam int STG_REF   = 3;
  localparam int STG_SING0 = 4;
  localparam int A_DLY     = 0;
  localparam int A_WID     = A_DLY + NSTAGE;
  localparam int A_BYP     = A_WID + NSTAGE;
  localparam int A_PS_PRI  = A_BYP + 1;
  localparam int A_PS_SEC  = A_PS_PRI + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_DLY, ST_GATE} gate_st_t;
endpackage

// File: rtl/ctf_sync_edge.sv
module ctf_sync_edge (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_pulse
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], async_in};
  end

  assign edge_pulse = sh[1] & ~sh[2];

  AST_EDGE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    edge_pulse |=> !edge_pulse); // R1
endmodule

// File: rtl/ctf_gate_delay.sv
module ctf_gate_delay
  import ctf_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             byp,
  input  logic [CNT_W-1:0] dly,
  input  logic [CNT_W-1:0] wid,
  input  logic             trig_in,
  output logic             gate_out
);
  gate_st_t         st;
  logic [CNT_W-1:0] cnt;
  logic             in_d;
  logic             start;

  assign start = trig_in & ~in_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= ST_IDLE;
      cnt  <= '0;
      in_d <= 1'b0;
    end else begin
      in_d <= trig_in;
      if (clr) begin
        st  <= ST_IDLE;
        cnt <= '0;
      end else begin
        case (st)
          ST_IDLE: if (start && !byp) begin
            st  <= ST_DLY;
            cnt <= dly;
          end
          ST_DLY: if (cnt <= CNT_W'(1)) begin
            st  <= ST_GATE;
            cnt <= wid;
          end else begin
            cnt <= cnt - 1'b1;
          end
          ST_GATE: if (cnt <= CNT_W'(1)) begin
            st  <= ST_IDLE;
            cnt <= '0;
          end else begin
            cnt <= cnt - 1'b1;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  assign gate_out = byp ? trig_in : (st == ST_GATE);

  AST_CLR_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    clr |=> (st == ST_IDLE)); // R9
  AST_NO_RETRIGGER: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DLY && !clr) |=> (st != ST_IDLE)); // R8
endmodule

// File: rtl/ctf_prescaler.sv
module ctf_prescaler #(
  parameter int PS_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic [PS_W-1:0] n,
  input  logic            trig_in,
  output logic            pulse_out
);
  logic [PS_W-1:0] cnt;
  logic [PS_W:0]   nxt;
  logic            in_d;

  assign nxt = {1'b0, cnt} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      in_d      <= 1'b0;
      pulse_out <= 1'b0;
    end else begin
      in_d      <= trig_in;
      pulse_out <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (trig_in && !in_d && n != '0) begin
        pulse_out <= (cnt == '0);
        cnt       <= (nxt >= {1'b0, n}) ? '0 : nxt[PS_W-1:0];
      end
    end
  end

  AST_PS_SINGLE: assert property (@(posedge clk) disable iff (rst)
    pulse_out |=> !pulse_out); // R6
  AST_PS_RANGE: assert property (@(posedge clk) disable iff (rst)
    (n != '0) |-> (cnt < n)); // R7
endmodule

// File: rtl/coinc_trigger_former.sv
module coinc_trigger_former
  import ctf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_pri,
  input  logic              src_sec,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DATA_W-1:0] cfg_wdata,
  output logic              coinc_out,
  output logic              single_pri_out,
  output logic              single_sec_out
);
  logic [DATA_W-1:0] dly_q [NSTAGE];
  logic [DATA_W-1:0] wid_q [NSTAGE];
  logic [NSTAGE-1:0] byp_q;
  logic [DATA_W-1:0] ps_q  [2];

  logic [1:0] src_async;
  logic [1:0] src_pulse;
  logic [1:0] src_gate;
  logic [1:0] sing_dly;
  logic [1:0] sing_pulse;
  logic       raw_coinc;
  logic       wid_out;
  logic       ref_out;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NSTAGE; i++) begin
        dly_q[i] <= DATA_W'(1);
        wid_q[i] <= DATA_W'(1);
      end
      byp_q   <= '0;
      ps_q[0] <= DATA_W'(1);
      ps_q[1] <= DATA_W'(1);
    end else if (cfg_we) begin
      for (int i = 0; i < NSTAGE; i++) begin
        if (cfg_addr == ADDR_W'(A_DLY + i)) dly_q[i] <= cfg_wdata;
        if (cfg_addr == ADDR_W'(A_WID + i)) wid_q[i] <= cfg_wdata;
      end
      if (cfg_addr == ADDR_W'(A_BYP))    byp_q   <= cfg_wdata[NSTAGE-1:0];
      if (cfg_addr == ADDR_W'(A_PS_PRI)) ps_q[0] <= cfg_wdata;
      if (cfg_addr == ADDR_W'(A_PS_SEC)) ps_q[1] <= cfg_wdata;
    end
  end

  assign src_async = {src_sec, src_pri};

  for (genvar s = 0; s < 2; s++) begin : g_src
    ctf_sync_edge u_sync (
      .clk(clk), .rst(rst), .async_in(src_async[s]), .edge_pulse(src_pulse[s])
    );
    ctf_gate_delay #(.CNT_W(DATA_W)) u_gate (
      .clk(clk), .rst(rst), .clr(cfg_we),
      .byp(byp_q[STG_GATE0 + s]), .dly(dly_q[STG_GATE0 + s]), .wid(wid_q[STG_GATE0 + s]),
      .trig_in(src_pulse[s]), .gate_out(src_gate[s])
    );
    ctf_gate_delay #(.CNT_W(DATA_W)) u_sdly (
      .clk(clk), .rst(rst), .clr(cfg_we),
      .byp(byp_q[STG_SING0 + s]), .dly(dly_q[STG_SING0 + s]), .wid(wid_q[STG_SING0 + s]),
      .trig_in(src_pulse[s]), .gate_out(sing_dly[s])
    );
    ctf_prescaler #(.PS_W(DATA_W)) u_ps (
      .clk(clk), .rst(rst), .clr(cfg_we), .n(ps_q[s]),
      .trig_in(sing_dly[s]), .pulse_out(sing_pulse[s])
    );
  end

  assign raw_coinc = &src_gate;

  ctf_gate_delay #(.CNT_W(DATA_W)) u_widen (
    .clk(clk), .rst(rst), .clr(cfg_we),
    .byp(byp_q[STG_WIDEN]), .dly(dly_q[STG_WIDEN]), .wid(wid_q[STG_WIDEN]),
    .trig_in(raw_coinc), .gate_out(wid_out)
  );

  ctf_gate_delay #(.CNT_W(DATA_W)) u_ref (
    .clk(clk), .rst(rst), .clr(cfg_we),
    .byp(byp_q[STG_REF]), .dly(dly_q[STG_REF]), .wid(wid_q[STG_REF]),
    .trig_in(src_pulse[0]), .gate_out(ref_out)
  );

  always_ff @(posedge clk) begin
    if (rst) coinc_out <= 1'b0;
    else     coinc_out <= wid_out & ref_out;
  end

  assign single_pri_out = sing_pulse[0];
  assign single_sec_out = sing_pulse[1];

  AST_COINC_NEEDS_REF: assert property (@(posedge clk) disable iff (rst)
    coinc_out |-> $past(ref_out)); // R4
  AST_COINC_NEEDS_WIDEN: assert property (@(posedge clk) disable iff (rst)
    coinc_out |-> $past(wid_out)); // R3
endmodule

// File: tb/coinc_trigger_former_test.sv
module coinc_trigger_former_test;
  localparam int DW = 8;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic src_pri = 1'b0, src_sec = 1'b0;
  logic cfg_we = 1'b0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic coinc_out, single_pri_out, single_sec_out;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int c_first, c_len, p_first, p_cnt, s_first, s_cnt;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  coinc_trigger_former #(.DATA_W(DW), .ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .src_pri(src_pri), .src_sec(src_sec),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
    .coinc_out(coinc_out), .single_pri_out(single_pri_out), .single_sec_out(single_sec_out)
  );

  typedef struct packed {
    logic [7:0] d0, w0, d1, w1, d2, w2, d3, w3, byp, op, os, first, len;
  } vec_t;

  localparam vec_t VEC [7] = '{
    '{8'd2, 8'd10, 8'd2, 8'd10, 8'd1, 8'd4, 8'd8,  8'd3, 8'h00, 8'd0, 8'd3,  8'd12, 8'd3},
    '{8'd2, 8'd10, 8'd2, 8'd10, 8'd1, 8'd4, 8'd10, 8'd6, 8'h00, 8'd0, 8'd3,  8'd14, 8'd1},
    '{8'd2, 8'd10, 8'd2, 8'd10, 8'd1, 8'd4, 8'd10, 8'd6, 8'h04, 8'd0, 8'd3,  8'd14, 8'd2},
    '{8'd2, 8'd10, 8'd2, 8'd10, 8'd1, 8'd4, 8'd8,  8'd3, 8'h00, 8'd0, 8'd15, 8'd0,  8'd0},
    '{8'd1, 8'd1,  8'd1, 8'd1,  8'd1, 8'd1, 8'd1,  8'd1, 8'h0F, 8'd0, 8'd0,  8'd3,  8'd1},
    '{8'd1, 8'd1,  8'd1, 8'd1,  8'd3, 8'd5, 8'd1,  8'd1, 8'h0B, 8'd0, 8'd0,  8'd0,  8'd0},
    '{8'd1, 8'd3,  8'd1, 8'd10, 8'd1, 8'd2, 8'd2,  8'd4, 8'h00, 8'd4, 8'd0,  8'd11, 8'd2}
  };

  task automatic check(input int act, input int exp, input string req, input string what);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = AW'(a); cfg_wdata = DW'(d);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run(input logic [63:0] pm, input logic [63:0] sm, input int wr_k);
    int base;
    c_first = -1; c_len = 0; p_first = -1; p_cnt = 0; s_first = -1; s_cnt = 0;
    @(negedge clk);
    base = cyc;
    for (int k = 0; k < 64; k++) begin
      if (coinc_out) begin if (c_len == 0) c_first = cyc - base; c_len++; end
      if (single_pri_out) begin if (p_cnt == 0) p_first = cyc - base; p_cnt++; end
      if (single_sec_out) begin if (s_cnt == 0) s_first = cyc - base; s_cnt++; end
      src_pri = pm[k] | (k > 0 && pm[k-1]);
      src_sec = sm[k] | (k > 0 && sm[k-1]);
      if (k == wr_k) begin cfg_we = 1'b1; cfg_addr = AW'(14); cfg_wdata = DW'(1); end
      else cfg_we = 1'b0;
      @(negedge clk);
    end
    src_pri = 1'b0; src_sec = 1'b0; cfg_we = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_default;
    for (int i = 0; i < 6; i++) begin wr(i, 1); wr(6 + i, 1); end
    wr(12, 0); wr(13, 1); wr(14, 1);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic [63:0] seven;
    repeat (3) @(negedge clk);
    // R10 reset state
    check(coinc_out, 0, "R10", "coinc_out in reset");
    check(single_pri_out, 0, "R10", "single_pri_out in reset");
    rst = 1'b0;
    @(negedge clk);
    check(single_sec_out, 0, "R10", "single_sec_out after reset");

    // R10 default settings: delay 1 -> single_pri after edge E+4
    run(64'h1, 64'h0, -1);
    check(p_first, 5, "R10", "default single_pri timing");

    // table of coincidence vectors (R2 R3 R4 R5)
    for (int i = 0; i < 7; i++) begin
      wr(0, VEC[i].d0); wr(6, VEC[i].w0);
      wr(1, VEC[i].d1); wr(7, VEC[i].w1);
      wr(2, VEC[i].d2); wr(8, VEC[i].w2);
      wr(3, VEC[i].d3); wr(9, VEC[i].w3);
      wr(12, VEC[i].byp);
      run(64'h1 << VEC[i].op, 64'h1 << VEC[i].os, -1);
      check(c_len, int'(VEC[i].len), "R4", $sformatf("vector %0d coinc length", i));
      if (VEC[i].len != 0)
        check(c_first, int'(VEC[i].first), "R2", $sformatf("vector %0d coinc first cycle", i));
    end

    // R6 R1 singles delay, input held two cycles gives one pulse
    cfg_default(); wr(4, 3);
    run(64'h1, 64'h0, -1);
    check(p_first, 7, "R6", "single_pri timing delay 3");
    check(p_cnt, 1, "R1", "one pulse per held input");
    wr(5, 2);
    run(64'h0, 64'h1, -1);
    check(s_first, 6, "R6", "single_sec timing delay 2");

    // R5 bypass of the primary singles delay
    wr(12, 8'h10);
    run(64'h1, 64'h0, -1);
    check(p_first, 3, "R5", "bypassed singles stage timing");
    wr(12, 0);

    // R7 downscaler
    seven = 64'h1 | (64'h1 << 6) | (64'h1 << 12) | (64'h1 << 18) | (64'h1 << 24) | (64'h1 << 30) | (64'h1 << 36);
    wr(4, 1); wr(13, 3);
    run(seven, 64'h0, -1);
    check(p_cnt, 3, "R7", "prescale 3 of 7 pulses");
    check(p_first, 5, "R7", "prescale starts with first pulse");
    wr(13, 0);
    run(seven, 64'h0, -1);
    check(p_cnt, 0, "R7", "prescale 0 blocks");
    wr(13, 1);
    run(seven, 64'h0, -1);
    check(p_cnt, 7, "R7", "prescale 1 passes all");

    // R8 retrigger ignored while busy
    wr(4, 5);
    run(64'h1 | (64'h1 << 4), 64'h0, -1);
    check(p_cnt, 1, "R8", "retrigger during delay ignored");
    run(64'h1 | (64'h1 << 10), 64'h0, -1);
    check(p_cnt, 2, "R8", "pulse after stage idle accepted");

    // R9 write clears stage in progress
    wr(4, 10);
    run(64'h1, 64'h0, -1);
    check(p_first, 14, "R9", "baseline without write");
    run(64'h1, 64'h0, 5);
    check(p_cnt, 0, "R9", "write clears pending gate");

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule